// File: doc/BRIEF.md
# Modulus Counter with Selectable Clock and Load Control

This block is a 16-bit up-counter that counts from a programmable starting value instead of from zero. Each time it passes 0xFFFF it restarts from a 16-bit modulus register. A 16-bit control register decides what advances the counter. The choices are a rising edge or a falling edge on an external clock pin, the tick of an internal 8-bit prescaler, or nothing. An external load pin can restart the counter from the modulus register. The register also decides which transitions of that pin do this.

Both pins are sampled through two-flop synchronisers. A one-cycle pulse is raised for each edge seen. The prescaler counts up once per system clock from a value held in a byte-wide field of the control register. That field holds the two's complement of the divide ratio. A new field value takes effect only at the prescaler's next rollover, or at once when a control write selects the prescaler as the clock. A freeze-enable bit lets a global freeze input hold both the counter and the prescaler. The live levels of both synchronised pins can be read back.

Top module: `modulus_counter`

## Requirements
- R1: The control read word is laid out, bit 15 down to bit 0, as: clock-pin level, load-pin level, freeze enable, falling-edge load enable, rising-edge load enable, clock select (2 bits, bits 10:9), reserved bit 8, and prescaler field (bits 7:0). Bit 8 always reads 0, even after a write of 1.
- R2: Bits 15 and 14 show the clock-pin and load-pin levels after a two-flop synchroniser. A pin change becomes visible at the second clock edge after it. Writes to these bits have no effect.
- R3: Clock select 00 stops the counter. Edges on the clock pin and prescaler activity then leave the count unchanged.
- R4: Clock select 01 adds one count per low-to-high transition of the clock pin. Clock select 10 adds one count per high-to-low transition. The count changes at the third clock edge after the pin changes.
- R5: With clock select 11, the prescaler counts up once per clock. When it is at 0xFF, it gives one count pulse and reloads from the field. The counter therefore advances once every 256 minus field cycles, and a field of 0x00 divides by 256.
- R6: A new prescaler field reaches the prescaler at its next rollover. The one exception is a control-register write whose clock select is 11: that write loads the written field into the prescaler in the same cycle.
- R7: A byte write replaces only the prescaler field. All other control bits keep their values.
- R8: A count step taken at 0xFFFF loads the modulus register into the counter, not zero.
- R9: The load edge enables work as {falling, rising}. 00 gives no load, 01 loads on a low-to-high load-pin transition, 10 loads on a high-to-low transition, and 11 loads on both. A load copies the modulus register into the counter.
- R10: When a load event and a count step fall in the same cycle, the counter takes the modulus value and no increment is applied.
- R11: When freeze enable is 1 and the freeze input is high, the counter and the prescaler hold their values, and load events are ignored. When freeze enable is 0, the freeze input has no effect.
- R12: After reset the counter, the modulus register and every control field are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| freezeIn | input | 1 | Global freeze request |
| clkPin | input | 1 | External count clock pin (asynchronous) |
| loadPin | input | 1 | External load pin (asynchronous) |
| ctlWrEn | input | 1 | Write the whole control register from wrData |
| preWrEn | input | 1 | Write only the prescaler field from wrData[7:0] |
| wrData | input | 16 | Control write data |
| modWrEn | input | 1 | Write the modulus register |
| modWrData | input | 16 | Modulus write data |
| ctlRdData | output | 16 | Control register read value |
| countOut | output | 16 | Current counter value |

## Verification
The bench aims at the prescaler reload timing. A design that loaded a byte-written field at once would speed up straight away. A design that ignored a select-11 write would keep the stale divide ratio for a full prescaler period. Both are caught by measuring the exact cycle of the next count. The bench also drives the count past 0xFFFF, where a design that wraps to zero shows up. It makes a load edge coincide with a prescaler tick every cycle, so that an extra increment after the load is visible. It also writes ones into the read-only and reserved bits, and checks that a freeze with the enable clear still counts. Random pin toggling, freezes and register writes are checked cycle by cycle against a bench model built from the requirements.

// File: rtl/modulus_counter_pkg.sv
package modulus_counter_pkg;

  localparam int REG_W   = 16;
  localparam int PRE_W   = 8;

  // Bit positions in the control word (behavioural layout).
  localparam int BIT_CLK_LVL = 15;
  localparam int BIT_LD_LVL  = 14;
  localparam int BIT_FRZ     = 13;
  localparam int BIT_LD_FALL = 12;
  localparam int BIT_LD_RISE = 11;
  localparam int SEL_HI      = 10;
  localparam int SEL_LO      = 9;
  localparam int BIT_RSVD    = 8;

  typedef enum logic [1:0] {
    SEL_OFF      = 2'b00,
    SEL_PIN_RISE = 2'b01,
    SEL_PIN_FALL = 2'b10,
    SEL_PRESCALE = 2'b11
  } clk_sel_e;

  typedef struct packed {
    logic countStb;
    logic loadStb;
  } strobe_t;

endpackage

// File: rtl/modulus_counter_sync.sv
module modulus_counter_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic pinLvl,
  output logic pinRise,
  output logic pinFall
);

  logic [STAGES-1:0] chain;
  logic              prevLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain   <= '0;
      prevLvl <= 1'b0;
    end else begin
      chain   <= {chain[STAGES-2:0], pinIn};
      prevLvl <= chain[STAGES-1];
    end
  end

  assign pinLvl  = chain[STAGES-1];
  assign pinRise = pinLvl & ~prevLvl;
  assign pinFall = ~pinLvl & prevLvl;

  // An edge pulse lasts exactly one cycle.
  assert_edge_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pinRise || pinFall) |=> !(pinRise || pinFall) || $changed(pinLvl));

endmodule

// File: rtl/modulus_counter_ctrl.sv
module modulus_counter_ctrl
  import modulus_counter_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             freezeIn,
  input  logic             clkPin,
  input  logic             loadPin,
  input  logic             ctlWrEn,
  input  logic             preWrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] ctlRd,
  output strobe_t          strb
);

  localparam int NUM_PINS = 2;
  localparam int PIN_CLK  = 0;
  localparam int PIN_LOAD = 1;
  localparam logic [PRE_W-1:0] PRE_TOP = '1;

  logic [NUM_PINS-1:0] pinIn, pinLvl, pinRise, pinFall;

  assign pinIn[PIN_CLK]  = clkPin;
  assign pinIn[PIN_LOAD] = loadPin;

  for (genvar i = 0; i < NUM_PINS; i++) begin : gSync
    modulus_counter_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk),
      .rstN   (rstN),
      .pinIn  (pinIn[i]),
      .pinLvl (pinLvl[i]),
      .pinRise(pinRise[i]),
      .pinFall(pinFall[i])
    );
  end

  logic             frzEn, ldFall, ldRise;
  clk_sel_e         clkSel;
  logic [PRE_W-1:0] presField, presCnt;

  logic     frozen, presRun, presTick, selReload, cntEn, loadEv;
  clk_sel_e newSel;

  assign frozen    = frzEn & freezeIn;
  assign presRun   = (clkSel == SEL_PRESCALE) && !frozen;
  assign presTick  = presRun && (presCnt == PRE_TOP);
  assign newSel    = clk_sel_e'(wrData[SEL_HI:SEL_LO]);
  assign selReload = ctlWrEn && (newSel == SEL_PRESCALE);

  // Control register; the pin levels and the reserved bit have no storage.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frzEn     <= 1'b0;
      ldFall    <= 1'b0;
      ldRise    <= 1'b0;
      clkSel    <= SEL_OFF;
      presField <= '0;
    end else if (ctlWrEn) begin
      frzEn     <= wrData[BIT_FRZ];
      ldFall    <= wrData[BIT_LD_FALL];
      ldRise    <= wrData[BIT_LD_RISE];
      clkSel    <= newSel;
      presField <= wrData[PRE_W-1:0];
    end else if (preWrEn) begin
      presField <= wrData[PRE_W-1:0];
    end
  end

  // Prescaler: counts up, reloads the field on rollover or on a select write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presCnt <= '0;
    end else if (selReload) begin
      presCnt <= wrData[PRE_W-1:0];
    end else if (presRun) begin
      presCnt <= presTick ? presField : presCnt + 1'b1;
    end
  end

  always_comb begin
    unique case (clkSel)
      SEL_PIN_RISE: cntEn = pinRise[PIN_CLK];
      SEL_PIN_FALL: cntEn = pinFall[PIN_CLK];
      SEL_PRESCALE: cntEn = presTick;
      default:      cntEn = 1'b0;
    endcase
  end

  assign loadEv = (ldRise & pinRise[PIN_LOAD]) | (ldFall & pinFall[PIN_LOAD]);

  assign strb.countStb = cntEn & !frozen;
  assign strb.loadStb  = loadEv & !frozen;

  assign ctlRd = {pinLvl[PIN_CLK], pinLvl[PIN_LOAD], frzEn, ldFall, ldRise,
                  clkSel, 1'b0, presField};

  assert_prescale_reload_R5: assert property (@(posedge clk) disable iff (!rstN)
    (presTick && !selReload) |=> presCnt == $past(presField));

  assert_select_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    selReload |=> presCnt == $past(wrData[PRE_W-1:0]));

  assert_prescale_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && !ctlWrEn) |=> $stable(presCnt));

  assert_byte_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (preWrEn && !ctlWrEn) |=> $stable(ctlRd[SEL_HI:BIT_LD_RISE]) && $stable(clkSel));

endmodule

// File: rtl/modulus_counter_dp.sv
module modulus_counter_dp
  import modulus_counter_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic             modWrEn,
  input  logic [CNT_W-1:0] modWrData,
  output logic [CNT_W-1:0] countOut
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] modReg, cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modReg <= '0;
    end else if (modWrEn) begin
      modReg <= modWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.loadStb) begin
      cnt <= modReg;
    end else if (strb.countStb) begin
      cnt <= (cnt == CNT_TOP) ? modReg : cnt + 1'b1;
    end
  end

  assign countOut = cnt;

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadStb |=> cnt == $past(modReg));

  assert_overflow_reload_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countStb && !strb.loadStb && cnt == CNT_TOP) |=> cnt == $past(modReg));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.countStb && !strb.loadStb) |=> $stable(cnt));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countStb && !strb.loadStb && cnt != CNT_TOP) |=>
      cnt == CNT_W'($past(cnt) + 1'b1));

endmodule

// File: rtl/modulus_counter.sv
module modulus_counter
  import modulus_counter_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             freezeIn,
  input  logic             clkPin,
  input  logic             loadPin,
  input  logic             ctlWrEn,
  input  logic             preWrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             modWrEn,
  input  logic [CNT_W-1:0] modWrData,
  output logic [REG_W-1:0] ctlRdData,
  output logic [CNT_W-1:0] countOut
);

  strobe_t strb;

  modulus_counter_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .freezeIn(freezeIn),
    .clkPin  (clkPin),
    .loadPin (loadPin),
    .ctlWrEn (ctlWrEn),
    .preWrEn (preWrEn),
    .wrData  (wrData),
    .ctlRd   (ctlRdData),
    .strb    (strb)
  );

  modulus_counter_dp #(.CNT_W(CNT_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .modWrEn  (modWrEn),
    .modWrData(modWrData),
    .countOut (countOut)
  );

endmodule

// File: tb/modulus_counter_tb_top.sv
`timescale 1ns/1ps
module modulus_counter_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        freezeIn = 1'b0, clkPin = 1'b0, loadPin = 1'b0;
  logic        ctlWrEn = 1'b0, preWrEn = 1'b0, modWrEn = 1'b0;
  logic [15:0] wrData = '0, modWrData = '0;
  logic [15:0] ctlRdData, countOut;

  always #2.5 clk = ~clk;

  modulus_counter dut_i (
    .clk(clk), .rstN(rstN), .freezeIn(freezeIn), .clkPin(clkPin),
    .loadPin(loadPin), .ctlWrEn(ctlWrEn), .preWrEn(preWrEn), .wrData(wrData),
    .modWrEn(modWrEn), .modWrData(modWrData), .ctlRdData(ctlRdData),
    .countOut(countOut)
  );

  int    nChecks = 0, nErr = 0, cycles = 0;
  bit    cmpOn = 1'b0;
  string curReq = "R12";

  // Reference model written from the requirements.
  logic [2:0]  mC, mL;
  logic        mFrz, mFall, mRise;
  logic [1:0]  mSel;
  logic [7:0]  mField, mPres;
  logic [15:0] mMod, mCnt;

  always @(posedge clk) begin : modelBlk
    logic frz, tick, cen, lev, pr, pf, lr, lf;
    if (!rstN) begin
      mC <= '0; mL <= '0; mFrz <= 0; mFall <= 0; mRise <= 0; mSel <= 0;
      mField <= '0; mPres <= '0; mMod <= '0; mCnt <= '0;
    end else begin
      frz  = mFrz & freezeIn;
      pr   = mC[1] & ~mC[2];  pf = ~mC[1] & mC[2];
      lr   = mL[1] & ~mL[2];  lf = ~mL[1] & mL[2];
      tick = (mSel == 2'b11) && !frz && (mPres == 8'hFF);
      case (mSel)
        2'b01:   cen = pr;
        2'b10:   cen = pf;
        2'b11:   cen = tick;
        default: cen = 1'b0;
      endcase
      lev = ((mRise & lr) | (mFall & lf)) & !frz;
      mC <= {mC[1:0], clkPin};
      mL <= {mL[1:0], loadPin};
      if (modWrEn) mMod <= modWrData;
      if (lev) mCnt <= mMod;
      else if (cen && !frz) mCnt <= (mCnt == 16'hFFFF) ? mMod : mCnt + 16'd1;
      if (ctlWrEn) begin
        mFrz <= wrData[13]; mFall <= wrData[12]; mRise <= wrData[11];
        mSel <= wrData[10:9]; mField <= wrData[7:0];
      end else if (preWrEn) mField <= wrData[7:0];
      if (ctlWrEn && wrData[10:9] == 2'b11) mPres <= wrData[7:0];
      else if (mSel == 2'b11 && !frz) mPres <= (mPres == 8'hFF) ? mField : mPres + 8'd1;
    end
  end

  function automatic logic [15:0] expRead();
    return {mC[1], mL[1], mFrz, mFall, mRise, mSel, 1'b0, mField};
  endfunction

  function automatic logic [15:0] ctlWord(bit frz, bit fall, bit rise,
                                          logic [1:0] sel, logic [7:0] pre);
    return {2'b00, frz, fall, rise, sel, 1'b0, pre};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (cmpOn) begin
    check(curReq, "count vs model", countOut, mCnt);
    check(curReq, "register vs model", ctlRdData, expRead());
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nErr++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  task automatic wait1(int n); repeat (n) @(negedge clk); endtask

  task automatic wrCtl(logic [15:0] d);
    ctlWrEn = 1'b1; wrData = d; wait1(1); ctlWrEn = 1'b0;
  endtask
  task automatic wrByte(logic [7:0] b);
    preWrEn = 1'b1; wrData = {8'h00, b}; wait1(1); preWrEn = 1'b0;
  endtask
  task automatic wrMod(logic [15:0] v);
    modWrEn = 1'b1; modWrData = v; wait1(1); modWrEn = 1'b0;
  endtask
  task automatic clkPulse(); clkPin = 1'b1; wait1(4); clkPin = 1'b0; wait1(4); endtask
  task automatic loadPulse(); loadPin = 1'b1; wait1(4); loadPin = 1'b0; wait1(4); endtask

  initial begin
    logic [15:0] c0;
    void'($urandom(32'd2024));
    wait1(3);
    rstN = 1'b1;
    wait1(1);
    // R12: reset state
    check("R12", "count after reset", countOut, 16'h0000);
    check("R12", "register after reset", ctlRdData, 16'h0000);
    cmpOn = 1'b1;

    // R1: layout and reserved bit
    curReq = "R1";
    wrCtl(ctlWord(1, 0, 1, 2'b10, 8'h5A) | 16'h0100);
    check("R1", "layout, reserved bit zero", ctlRdData, 16'h2C5A);
    wrCtl(16'h0000);

    // R2: synchronised pin levels, read-only
    curReq = "R2";
    clkPin = 1'b1;
    wait1(1);
    check("R2", "clock level after one edge", ctlRdData[15], 1'b0);
    wait1(1);
    check("R2", "clock level after two edges", ctlRdData[15], 1'b1);
    wrCtl(16'h4000);
    check("R2", "write to status bits ignored", ctlRdData[15:14], 2'b10);
    clkPin = 1'b0; wait1(4);

    // R4: rising and falling pin counting
    curReq = "R4";
    wrCtl(ctlWord(0, 0, 0, 2'b01, 8'h00));
    c0 = countOut;
    clkPin = 1'b1; wait1(2);
    check("R4", "no count before third edge", countOut, c0);
    wait1(1);
    check("R4", "count at third edge", countOut, c0 + 16'd1);
    clkPin = 1'b0; wait1(4);
    for (int i = 0; i < 4; i++) clkPulse();
    check("R4", "five rising edges", countOut, c0 + 16'd5);
    wrCtl(ctlWord(0, 0, 0, 2'b10, 8'h00));
    c0 = countOut;
    for (int i = 0; i < 3; i++) clkPulse();
    check("R4", "three falling edges", countOut, c0 + 16'd3);

    // R3: disabled clock
    curReq = "R3";
    wrCtl(ctlWord(0, 0, 0, 2'b00, 8'hFF));
    c0 = countOut;
    for (int i = 0; i < 4; i++) clkPulse();
    check("R3", "select 00 holds count", countOut, c0);

    // R9 / R8: loads and overflow
    curReq = "R9";
    wrMod(16'hFFFE);
    wrCtl(ctlWord(0, 0, 1, 2'b00, 8'h00));
    loadPulse();
    check("R9", "rising load", countOut, 16'hFFFE);
    curReq = "R8";
    wrMod(16'h1234);
    wrCtl(ctlWord(0, 0, 1, 2'b01, 8'h00));
    clkPulse();
    check("R8", "step to FFFF", countOut, 16'hFFFF);
    clkPulse();
    check("R8", "overflow reloads modulus", countOut, 16'h1234);
    curReq = "R9";
    wrMod(16'h0777);
    wrCtl(ctlWord(0, 1, 0, 2'b00, 8'h00));
    loadPin = 1'b1; wait1(4);
    check("R9", "fall-only ignores rising load", countOut, 16'h1234);
    loadPin = 1'b0; wait1(4);
    check("R9", "fall-only loads on falling", countOut, 16'h0777);
    wrMod(16'h0AAA);
    wrCtl(ctlWord(0, 0, 0, 2'b00, 8'h00));
    loadPulse();
    check("R9", "no-load setting", countOut, 16'h0777);
    wrCtl(ctlWord(0, 1, 1, 2'b00, 8'h00));
    loadPin = 1'b1; wait1(4);
    check("R9", "both edges: rising", countOut, 16'h0AAA);
    wrMod(16'h0BBB);
    loadPin = 1'b0; wait1(4);
    check("R9", "both edges: falling", countOut, 16'h0BBB);

    // R5: prescaler divide ratios
    curReq = "R5";
    wrCtl(ctlWord(0, 0, 0, 2'b11, 8'hFE));
    c0 = countOut;
    wait1(4);
    check("R5", "field FE divides by 2", countOut, c0 + 16'd2);
    wrCtl(ctlWord(0, 0, 0, 2'b00, 8'h00));
    wrCtl(ctlWord(0, 0, 0, 2'b11, 8'h00));
    c0 = countOut;
    wait1(255);
    check("R5", "field 00 no count before 256", countOut, c0);
    wait1(1);
    check("R5", "field 00 divides by 256", countOut, c0 + 16'd1);

    // R6 / R7: deferred field update, byte write
    curReq = "R6";
    wrByte(8'hFE);
    check("R7", "byte write keeps other bits", ctlRdData[13:8], 6'b000110);
    check("R7", "byte write sets field", ctlRdData[7:0], 8'hFE);
    c0 = countOut;
    wait1(200);
    check("R6", "byte write not applied before rollover", countOut, c0);
    wait1(60);
    c0 = countOut;
    wait1(4);
    check("R6", "new field after rollover", countOut, c0 + 16'd2);
    wrCtl(ctlWord(0, 0, 0, 2'b11, 8'hF0));
    c0 = countOut;
    wait1(15);
    check("R6", "select write reload: no count yet", countOut, c0);
    wait1(1);
    check("R6", "select write reload: count at 16", countOut, c0 + 16'd1);

    // R10: load beats count
    curReq = "R10";
    wrMod(16'h0100);
    wrCtl(ctlWord(0, 0, 1, 2'b11, 8'hFF));
    loadPin = 1'b1; wait1(3);
    check("R10", "load wins over tick", countOut, 16'h0100);
    wait1(1);
    check("R10", "count resumes after load", countOut, 16'h0101);
    loadPin = 1'b0; wait1(2);

    // R11: freeze
    curReq = "R11";
    wrCtl(ctlWord(1, 0, 1, 2'b11, 8'hFF));
    freezeIn = 1'b1; wait1(1);
    c0 = countOut;
    wait1(10);
    loadPulse();
    check("R11", "frozen counter holds", countOut, c0);
    freezeIn = 1'b0; wait1(3);
    check("R11", "runs after freeze release", countOut, c0 + 16'd3);
    wrCtl(ctlWord(0, 0, 0, 2'b11, 8'hFF));
    freezeIn = 1'b1;
    c0 = countOut;
    wait1(5);
    check("R11", "freeze ignored when disabled", countOut, c0 + 16'd5);
    freezeIn = 1'b0;

    // Random traffic checked against the model each cycle
    curReq = "R9";
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      clkPin   = (r[3:0] < 4'd3) ? ~clkPin : clkPin;
      loadPin  = (r[7:4] == 4'd0) ? ~loadPin : loadPin;
      freezeIn = (r[11:8] == 4'd0) ? ~freezeIn : freezeIn;
      ctlWrEn  = (r[19:14] == 6'd0);
      preWrEn  = (r[25:20] == 6'd1);
      modWrEn  = (r[31:26] == 6'd2);
      wrData    = $urandom;
      modWrData = 16'hFFF0 | 16'($urandom % 16);
      wait1(1);
    end
    ctlWrEn = 0; preWrEn = 0; modWrEn = 0;
    wait1(2);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule